// File: doc/BRIEF.md
# Dual-Issue Dispatch Scoreboard Scheduler

This block sits between a two-wide decode front end and a small set of execution units. Each clock it can take in up to two decoded operations, each with an operation class, a destination register, two source registers and a tag. It holds them in a four-entry, age-ordered dispatch queue and uses a per-register busy bit to decide which ones may start. It grants up to two of them per clock to two single-cycle integer adders, one pipelined three-cycle multiplier and one unpipelined two-cycle floating-point adder.

Only timing and hazard control are modelled; no operand data moves through the block. An operation accepted at a clock edge spends at least one cycle in dispatch. Its grant is shown on the unit's issue outputs in its last dispatch cycle, and it executes for the unit's latency. Its completion then appears on that unit's writeback outputs in the state-update cycle that follows. Read-after-write, write-after-write and write-after-read conflicts against older operations, whether queued or in flight, hold a younger operation back. Otherwise ready operations may go ahead of blocked older ones.

Top module: `dual_issue_sched`

## Requirements
- R1: `in_ready` is high exactly when the queue holds at most two operations. When `in_ready` is high, each valid input slot is accepted at the clock edge, with slot 0 treated as older than slot 1.
- R2: An operation accepted at the edge that ends cycle t can be granted no earlier than cycle t+1.
- R3: An operation is not granted while one of its sources is the destination of an older operation that is still queued or has not yet reached its state-update.
- R4: An operation is not granted while its destination is the destination of an older operation that is not finished, or is a source of an older operation that is still queued.
- R5: At most two grants occur per cycle, and ready operations are taken oldest first. Unit indices are 0 and 1 for the adders (adder 0 is used first), 2 for the multiplier and 3 for the floating-point adder.
- R6: Class code 0 (ADD) produces writeback on its adder exactly 2 cycles after its grant.
- R7: Class code 1 (MUL) produces writeback exactly 4 cycles after its grant, and the multiplier accepts a new grant in every cycle.
- R8: Class code 2 (FADD) produces writeback exactly 3 cycles after its grant, and no FADD grant occurs in the cycle after an FADD grant.
- R9: A destination becomes free at the end of its state-update cycle. An operation waiting only on it is granted in the next cycle.
- R10: After reset the queue is empty, no grant or writeback is shown, and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 2 | Valid per input slot; slot 0 is older |
| in_cls | input | 4 | Class code per slot, 2 bits each (0 ADD, 1 MUL, 2 FADD) |
| in_dst | input | 2*REGW | Destination register per slot |
| in_src1 | input | 2*REGW | First source register per slot |
| in_src2 | input | 2*REGW | Second source register per slot |
| in_tag | input | 2*TAGW | Tag per slot |
| in_ready | output | 1 | Queue has room for two operations |
| issue_valid | output | NUM_ADD+2 | Grant per unit in this cycle |
| issue_tag | output | (NUM_ADD+2)*TAGW | Tag of the granted operation per unit |
| wb_valid | output | NUM_ADD+2 | State-update per unit in this cycle |
| wb_tag | output | (NUM_ADD+2)*TAGW | Tag completing per unit |
| wb_dst | output | (NUM_ADD+2)*REGW | Destination completing per unit |

## Verification
A busy bit that is set wrongly or stays set shows up as a grant that comes later than expected, often by several cycles, because one stalled operation delays its whole dependency chain. A bit that clears too early shows up as a grant made before its producer's writeback. A wrong latency stage count moves a writeback cycle at once. An ordering or unit-selection fault changes which unit index carries a tag in the grant cycle itself. The bench checks all of these by comparing exact grant cycles, unit indices and writeback cycles for several fixed traces.

// File: rtl/sched_pkg.sv
// Shared types for the dispatch scheduler.
// Assumes a 2-bit class code: 0 integer add, 1 multiply, 2 floating add.
package sched_pkg;
    typedef enum logic [1:0] {
        CLS_ADD  = 2'd0,
        CLS_MUL  = 2'd1,
        CLS_FADD = 2'd2
    } cls_e;
endpackage

// File: rtl/sched_scoreboard.sv
// Per-register pending-write bits.
// A bit is set when an operation writing that register is granted and
// cleared at the end of its state-update cycle. Assumes the picker never
// grants a write to a register that is still pending.
module sched_scoreboard #(
    parameter int NUM_REGS  = 8,
    parameter int REGW      = 3,
    parameter int NUM_UNITS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_UNITS-1:0] set_v,
    input  logic [REGW-1:0]      set_dst [NUM_UNITS],
    input  logic [NUM_UNITS-1:0] clr_v,
    input  logic [REGW-1:0]      clr_dst [NUM_UNITS],
    output logic [NUM_REGS-1:0]  busy
);
    logic [NUM_REGS-1:0] set_m;
    logic [NUM_REGS-1:0] clr_m;

    // Decode granted and completing destinations into register masks.
    always_comb begin
        set_m = '0;
        clr_m = '0;
        for (int u = 0; u < NUM_UNITS; u++) begin
            if (set_v[u]) set_m[set_dst[u]] = 1'b1;
            if (clr_v[u]) clr_m[clr_dst[u]] = 1'b1;
        end
    end

    // Update the pending bits; a new grant wins over a completion.
    always_ff @(posedge clk) begin
        if (!rst_n) busy <= '0;
        else        busy <= (busy & ~clr_m) | set_m;
    end

    AST_WAW_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (set_m & busy) == '0) else $error("grant to pending register"); // R4
    AST_WB_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_m & ~busy) == '0) else $error("writeback without pending write"); // R9
endmodule

// File: rtl/sched_unit_pipe.sv
// Timing model of one execution unit.
// A grant enters the first execute stage next cycle; after LAT execute
// stages the operation is shown as writeback for one cycle. When not
// pipelined, a new grant is refused until the current operation is in
// its last execute stage. Assumes LAT >= 1.
module sched_unit_pipe #(
    parameter int LAT       = 1,
    parameter bit PIPELINED = 1'b1,
    parameter int TAGW      = 3,
    parameter int REGW      = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue,
    input  logic [TAGW-1:0] issue_tag,
    input  logic [REGW-1:0] issue_dst,
    output logic            can_accept,
    output logic            wb_valid,
    output logic [TAGW-1:0] wb_tag,
    output logic [REGW-1:0] wb_dst
);
    logic [LAT:0]    stg_v;
    logic [TAGW-1:0] stg_tag [LAT+1];
    logic [REGW-1:0] stg_dst [LAT+1];

    // Advance the stage chain by one each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_v <= '0;
            for (int k = 0; k <= LAT; k++) begin
                stg_tag[k] <= '0;
                stg_dst[k] <= '0;
            end
        end else begin
            stg_v      <= {stg_v[LAT-1:0], issue};
            stg_tag[0] <= issue_tag;
            stg_dst[0] <= issue_dst;
            for (int k = 1; k <= LAT; k++) begin
                stg_tag[k] <= stg_tag[k-1];
                stg_dst[k] <= stg_dst[k-1];
            end
        end
    end

    generate
        if (PIPELINED) begin : g_pipe
            assign can_accept = 1'b1;
        end else begin : g_single
            // Refuse a grant while an operation has execute stages left after next cycle.
            always_comb begin
                can_accept = 1'b1;
                for (int k = 0; k < LAT - 1; k++)
                    if (stg_v[k]) can_accept = 1'b0;
            end
            if (LAT >= 2) begin : g_chk
                AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
                    issue |-> !stg_v[0]) else $error("unpipelined unit overlapped"); // R8
            end
        end
    endgenerate

    assign wb_valid = stg_v[LAT];
    assign wb_tag   = stg_tag[LAT];
    assign wb_dst   = stg_dst[LAT];
endmodule

// File: rtl/sched_picker.sv
// Hazard check and oldest-first selection over the dispatch queue.
// Entry 0 is the oldest. An entry is ready when no pending or older queued
// write touches its sources or destination and no older queued operation
// still reads its destination. Up to MAX_ISSUE ready entries are granted,
// adders in index order, subject to each unit's acceptance.
module sched_picker
    import sched_pkg::*;
#(
    parameter int DEPTH     = 4,
    parameter int NUM_REGS  = 8,
    parameter int REGW      = 3,
    parameter int NUM_ADD   = 2,
    parameter int NUM_UNITS = NUM_ADD + 2,
    parameter int MAX_ISSUE = 2,
    parameter int IDXW      = 2
) (
    input  logic [DEPTH-1:0]     q_valid,
    input  cls_e                 q_cls [DEPTH],
    input  logic [REGW-1:0]      q_dst [DEPTH],
    input  logic [REGW-1:0]      q_s1  [DEPTH],
    input  logic [REGW-1:0]      q_s2  [DEPTH],
    input  logic [NUM_REGS-1:0]  busy,
    input  logic [NUM_UNITS-1:0] unit_ok,
    output logic [DEPTH-1:0]     take,
    output logic [NUM_UNITS-1:0] grant,
    output logic [IDXW-1:0]      sel [NUM_UNITS]
);
    localparam int MUL_U  = NUM_ADD;
    localparam int FADD_U = NUM_ADD + 1;

    logic [DEPTH-1:0] hz;

    // Flag entries held back by pending writes or older queued operations.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            hz[i] = busy[q_s1[i]] | busy[q_s2[i]] | busy[q_dst[i]];
            for (int j = 0; j < i; j++) begin
                if (q_valid[j] &&
                    (q_dst[j] == q_s1[i] || q_dst[j] == q_s2[i] ||
                     q_dst[j] == q_dst[i] ||
                     q_s1[j] == q_dst[i] || q_s2[j] == q_dst[i]))
                    hz[i] = 1'b1;
            end
        end
    end

    // Walk entries oldest first and hand out units.
    always_comb begin
        int n_iss;
        int n_add;
        n_iss = 0;
        n_add = 0;
        take  = '0;
        grant = '0;
        for (int u = 0; u < NUM_UNITS; u++) sel[u] = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (q_valid[i] && !hz[i] && n_iss < MAX_ISSUE) begin
                case (q_cls[i])
                    CLS_ADD: begin
                        for (int u = 0; u < NUM_ADD; u++) begin
                            if (!take[i] && !grant[u] && unit_ok[u]) begin
                                grant[u] = 1'b1;
                                sel[u]   = IDXW'(i);
                                take[i]  = 1'b1;
                            end
                        end
                        if (take[i]) n_add = n_add + 1;
                    end
                    CLS_MUL: begin
                        if (!grant[MUL_U] && unit_ok[MUL_U]) begin
                            grant[MUL_U] = 1'b1;
                            sel[MUL_U]   = IDXW'(i);
                            take[i]      = 1'b1;
                        end
                    end
                    CLS_FADD: begin
                        if (!grant[FADD_U] && unit_ok[FADD_U]) begin
                            grant[FADD_U] = 1'b1;
                            sel[FADD_U]   = IDXW'(i);
                            take[i]       = 1'b1;
                        end
                    end
                    default: ;
                endcase
                if (take[i]) n_iss = n_iss + 1;
            end
        end
    end
endmodule

// File: rtl/dual_issue_sched.sv
// Two-wide dispatch scheduler: age-ordered queue, scoreboard, unit models.
// Accepts up to two operations per clock when the queue has two free
// entries, keeps them compacted oldest-first, grants ready ones to the
// adders, multiplier and floating adder, and reports each completion.
// Assumes slot 0 is older than slot 1 and that tags are unique in flight.
module dual_issue_sched
    import sched_pkg::*;
#(
    parameter int DEPTH     = 4,
    parameter int NUM_REGS  = 8,
    parameter int REGW      = 3,
    parameter int TAGW      = 3,
    parameter int NUM_ADD   = 2,
    parameter int ADD_LAT   = 1,
    parameter int MUL_LAT   = 3,
    parameter int FADD_LAT  = 2,
    parameter int MAX_ISSUE = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [1:0]                   in_valid,
    input  logic [3:0]                   in_cls,
    input  logic [2*REGW-1:0]            in_dst,
    input  logic [2*REGW-1:0]            in_src1,
    input  logic [2*REGW-1:0]            in_src2,
    input  logic [2*TAGW-1:0]            in_tag,
    output logic                         in_ready,
    output logic [NUM_ADD+1:0]           issue_valid,
    output logic [(NUM_ADD+2)*TAGW-1:0]  issue_tag,
    output logic [NUM_ADD+1:0]           wb_valid,
    output logic [(NUM_ADD+2)*TAGW-1:0]  wb_tag,
    output logic [(NUM_ADD+2)*REGW-1:0]  wb_dst
);
    localparam int NUM_UNITS = NUM_ADD + 2;
    localparam int IDXW      = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW      = $clog2(DEPTH + 1);

    logic [DEPTH-1:0] q_valid, n_valid;
    cls_e             q_cls [DEPTH];
    cls_e             n_cls [DEPTH];
    logic [REGW-1:0]  q_dst [DEPTH], q_s1 [DEPTH], q_s2 [DEPTH];
    logic [REGW-1:0]  n_dst [DEPTH], n_s1 [DEPTH], n_s2 [DEPTH];
    logic [TAGW-1:0]  q_tag [DEPTH], n_tag [DEPTH];

    cls_e             s_cls [2];
    logic [REGW-1:0]  s_dst [2], s_s1 [2], s_s2 [2];
    logic [TAGW-1:0]  s_tag [2];

    logic [CNTW-1:0]      count;
    logic [1:0]           push;
    logic [DEPTH-1:0]     take, keep;
    logic [NUM_UNITS-1:0] grant, unit_ok, wbv;
    logic [IDXW-1:0]      sel [NUM_UNITS];
    logic [REGW-1:0]      g_dst [NUM_UNITS];
    logic [REGW-1:0]      w_dst [NUM_UNITS];
    logic [NUM_REGS-1:0]  busy;
    int                   rank [DEPTH];

    // Split the two input slots into fields.
    always_comb begin
        for (int k = 0; k < 2; k++) begin
            s_cls[k] = cls_e'(in_cls[2*k +: 2]);
            s_dst[k] = in_dst[k*REGW +: REGW];
            s_s1[k]  = in_src1[k*REGW +: REGW];
            s_s2[k]  = in_src2[k*REGW +: REGW];
            s_tag[k] = in_tag[k*TAGW +: TAGW];
        end
    end

    assign count    = CNTW'($countones(q_valid));
    assign in_ready = (count <= CNTW'(DEPTH - 2));
    assign push     = in_valid & {2{in_ready}};
    assign keep     = q_valid & ~take;

    // Build the next queue: survivors keep their age order, new slots append.
    always_comb begin
        int kept;
        int pos1;
        kept = 0;
        for (int i = 0; i < DEPTH; i++) begin
            rank[i] = kept;
            if (keep[i]) kept = kept + 1;
        end
        pos1 = kept + (push[0] ? 1 : 0);
        for (int p = 0; p < DEPTH; p++) begin
            n_valid[p] = 1'b0;
            n_cls[p]   = CLS_ADD;
            n_dst[p]   = '0;
            n_s1[p]    = '0;
            n_s2[p]    = '0;
            n_tag[p]   = '0;
            for (int i = 0; i < DEPTH; i++) begin
                if (keep[i] && rank[i] == p) begin
                    n_valid[p] = 1'b1;
                    n_cls[p]   = q_cls[i];
                    n_dst[p]   = q_dst[i];
                    n_s1[p]    = q_s1[i];
                    n_s2[p]    = q_s2[i];
                    n_tag[p]   = q_tag[i];
                end
            end
            for (int k = 0; k < 2; k++) begin
                if (push[k] && p == ((k == 0) ? kept : pos1)) begin
                    n_valid[p] = 1'b1;
                    n_cls[p]   = s_cls[k];
                    n_dst[p]   = s_dst[k];
                    n_s1[p]    = s_s1[k];
                    n_s2[p]    = s_s2[k];
                    n_tag[p]   = s_tag[k];
                end
            end
        end
    end

    // Register the queue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= '0;
            for (int p = 0; p < DEPTH; p++) begin
                q_cls[p] <= CLS_ADD;
                q_dst[p] <= '0;
                q_s1[p]  <= '0;
                q_s2[p]  <= '0;
                q_tag[p] <= '0;
            end
        end else begin
            q_valid <= n_valid;
            for (int p = 0; p < DEPTH; p++) begin
                q_cls[p] <= n_cls[p];
                q_dst[p] <= n_dst[p];
                q_s1[p]  <= n_s1[p];
                q_s2[p]  <= n_s2[p];
                q_tag[p] <= n_tag[p];
            end
        end
    end

    sched_picker #(
        .DEPTH(DEPTH), .NUM_REGS(NUM_REGS), .REGW(REGW), .NUM_ADD(NUM_ADD),
        .NUM_UNITS(NUM_UNITS), .MAX_ISSUE(MAX_ISSUE), .IDXW(IDXW)
    ) u_picker (
        .q_valid(q_valid), .q_cls(q_cls), .q_dst(q_dst), .q_s1(q_s1),
        .q_s2(q_s2), .busy(busy), .unit_ok(unit_ok), .take(take),
        .grant(grant), .sel(sel)
    );

    sched_scoreboard #(
        .NUM_REGS(NUM_REGS), .REGW(REGW), .NUM_UNITS(NUM_UNITS)
    ) u_board (
        .clk(clk), .rst_n(rst_n), .set_v(grant), .set_dst(g_dst),
        .clr_v(wbv), .clr_dst(w_dst), .busy(busy)
    );

    generate
        for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
            localparam int  LAT  = (u < NUM_ADD) ? ADD_LAT :
                                   (u == NUM_ADD) ? MUL_LAT : FADD_LAT;
            localparam bit  PIPE = (u == NUM_ADD + 1) ? 1'b0 : 1'b1;
            assign g_dst[u] = q_dst[sel[u]];
            assign issue_tag[u*TAGW +: TAGW] = q_tag[sel[u]];

            sched_unit_pipe #(
                .LAT(LAT), .PIPELINED(PIPE), .TAGW(TAGW), .REGW(REGW)
            ) u_pipe (
                .clk(clk), .rst_n(rst_n), .issue(grant[u]),
                .issue_tag(q_tag[sel[u]]), .issue_dst(q_dst[sel[u]]),
                .can_accept(unit_ok[u]), .wb_valid(wbv[u]),
                .wb_tag(wb_tag[u*TAGW +: TAGW]), .wb_dst(w_dst[u])
            );
            assign wb_dst[u*REGW +: REGW] = w_dst[u];

            AST_SOURCES_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                grant[u] |-> !busy[q_s1[sel[u]]] && !busy[q_s2[sel[u]]])
                else $error("grant with pending source"); // R3
        end
    endgenerate

    assign issue_valid = grant;
    assign wb_valid    = wbv;

    AST_TWO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant) <= MAX_ISSUE) else $error("too many grants"); // R5
endmodule

// File: tb/dual_issue_sched_test.sv
module dual_issue_sched_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  in_valid = '0;
    logic [3:0]  in_cls = '0;
    logic [5:0]  in_dst = '0, in_src1 = '0, in_src2 = '0, in_tag = '0;
    logic        in_ready;
    logic [3:0]  issue_valid, wb_valid;
    logic [11:0] issue_tag, wb_tag, wb_dst;

    dual_issue_sched uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cls(in_cls),
        .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2), .in_tag(in_tag),
        .in_ready(in_ready), .issue_valid(issue_valid), .issue_tag(issue_tag),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_dst(wb_dst)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int base   = 0;
    bit armed  = 0;
    int g_cyc [8], g_unit [8], w_cyc [8];
    int rdy_at [64];
    int p_cls [8], p_dst [8], p_s1 [8], p_s2 [8];

    always @(posedge clk) cyc <= cyc + 1;

    // Record grant cycle, unit and writeback cycle per tag.
    always @(negedge clk) begin
        if (armed) begin
            int rel;
            rel = cyc - base;
            if (rel >= 0 && rel < 64) rdy_at[rel] = int'(in_ready);
            for (int u = 0; u < 4; u++) begin
                if (issue_valid[u]) begin
                    g_cyc[issue_tag[u*3 +: 3]]  = rel;
                    g_unit[issue_tag[u*3 +: 3]] = u;
                end
                if (wb_valid[u]) w_cyc[wb_tag[u*3 +: 3]] = rel;
            end
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic prog(int t, int c, int d, int a, int b);
        p_cls[t] = c; p_dst[t] = d; p_s1[t] = a; p_s2[t] = b;
    endtask

    task automatic do_reset();
        armed = 0;
        in_valid = '0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Present tags k and k+1 until accepted.
    task automatic send_pair(int k);
        in_valid = 2'b11;
        in_cls   = {2'(p_cls[k+1]), 2'(p_cls[k])};
        in_dst   = {3'(p_dst[k+1]), 3'(p_dst[k])};
        in_src1  = {3'(p_s1[k+1]), 3'(p_s1[k])};
        in_src2  = {3'(p_s2[k+1]), 3'(p_s2[k])};
        in_tag   = {3'(k+1), 3'(k)};
        while (!in_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run(int n);
        do_reset();
        for (int t = 0; t < 8; t++) begin
            g_cyc[t] = -1; g_unit[t] = -1; w_cyc[t] = -1;
        end
        for (int t = 0; t < 64; t++) rdy_at[t] = -1;
        base  = cyc;
        armed = 1;
        for (int k = 0; k < n; k += 2) send_pair(k);
        in_valid = '0;
        repeat (24) @(negedge clk);
        armed = 0;
    endtask

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R10: state just after reset
        do_reset();
        chk("R10", "issue_valid", int'(issue_valid), 0);
        chk("R10", "wb_valid", int'(wb_valid), 0);
        chk("R10", "in_ready", int'(in_ready), 1);

        // Mixed trace with chained dependencies (class 0 ADD, 1 MUL, 2 FADD)
        prog(0, 0, 1, 2, 6);
        prog(1, 1, 3, 4, 5);
        prog(2, 2, 1, 2, 6);
        prog(3, 0, 2, 1, 3);
        prog(4, 1, 6, 7, 6);
        prog(5, 0, 3, 2, 1);
        run(6);
        chk("R2", "A grant", g_cyc[0], 1);
        chk("R5", "B grant", g_cyc[1], 1);
        chk("R9", "C grant", g_cyc[2], 4);
        chk("R3", "D grant", g_cyc[3], 8);
        chk("R4", "E grant", g_cyc[4], 5);
        chk("R3", "F grant", g_cyc[5], 11);
        chk("R6", "A wb", w_cyc[0], 3);
        chk("R7", "B wb", w_cyc[1], 5);
        chk("R8", "C wb", w_cyc[2], 7);
        chk("R6", "D wb", w_cyc[3], 10);
        chk("R7", "E wb", w_cyc[4], 9);
        chk("R6", "F wb", w_cyc[5], 13);
        chk("R5", "A unit", g_unit[0], 0);
        chk("R5", "B unit", g_unit[1], 2);
        chk("R5", "C unit", g_unit[2], 3);
        chk("R5", "E unit", g_unit[4], 2);
        chk("R1", "ready c2", rdy_at[2], 1);
        chk("R1", "ready c3", rdy_at[3], 0);
        chk("R1", "ready c5", rdy_at[5], 0);
        chk("R1", "ready c6", rdy_at[6], 1);

        // Four independent adds: both adders used, oldest first
        for (int t = 0; t < 4; t++) prog(t, 0, t + 1, 5, 6);
        run(4);
        for (int t = 0; t < 4; t++) begin
            chk("R5", "add grant", g_cyc[t], 1 + t / 2);
            chk("R5", "add unit", g_unit[t], t % 2);
            chk("R6", "add wb", w_cyc[t], 3 + t / 2);
        end

        // Two multiplies back to back, two floating adds back to back
        prog(0, 1, 1, 3, 4);
        prog(1, 1, 2, 3, 4);
        prog(2, 2, 5, 7, 7);
        prog(3, 2, 6, 7, 7);
        run(4);
        chk("R7", "mul0 grant", g_cyc[0], 1);
        chk("R7", "mul1 grant", g_cyc[1], 2);
        chk("R7", "mul0 wb", w_cyc[0], 5);
        chk("R7", "mul1 wb", w_cyc[1], 6);
        chk("R8", "fadd0 grant", g_cyc[2], 2);
        chk("R8", "fadd1 grant", g_cyc[3], 4);
        chk("R8", "fadd0 wb", w_cyc[2], 5);
        chk("R8", "fadd1 wb", w_cyc[3], 7);

        // Read-after-write wait and write-after-read block with overtaking
        prog(0, 0, 1, 2, 3);
        prog(1, 0, 4, 1, 1);
        prog(2, 1, 5, 6, 6);
        prog(3, 0, 6, 0, 0);
        run(4);
        chk("R2", "producer grant", g_cyc[0], 1);
        chk("R9", "consumer grant", g_cyc[1], 4);
        chk("R9", "consumer wb", w_cyc[1], 6);
        chk("R3", "mul overtakes", g_cyc[2], 2);
        chk("R4", "war grant", g_cyc[3], 3);
        chk("R5", "war unit", g_unit[3], 0);
        chk("R6", "war wb", w_cyc[3], 5);
        chk("R7", "mul wb", w_cyc[2], 6);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule